// File: doc/BRIEF.md
# Shared Peripheral Exchange Selector

This block sits between four I/O control units and one shared slow peripheral, a card punch. On a new I/O initiation it names the lowest-numbered I/O unit that is free. When a unit presents a descriptor, the block decodes the 5-bit unit-designate code and its qualifier bit. It decides whether the request is aimed at the punch or at the card reader that shares the same code. For a punch request it either admits the unit or refuses it with a busy pulse, so that the refused unit gives up rather than waits.

An admitted unit becomes the sole owner. Its enable flop closes the final gate of the exchange. The owner's four outgoing lines (start, clock pulse, stacker select, serial data) reach the punch through a common OR network. The punch's status and row-code lines are returned to the owner only. Ownership ends when the owner signals completion. A refused unit may try again later.

Top module: `xs_exchange`

## Requirements
- R1: When `init_req` is high, `init_sel` is one-hot on the lowest-indexed set bit of `io_free` (bit 0 is unit 1). When `init_req` is low it is zero. Both are combinational.
- R2: `init_none` is high exactly when `init_req` is high and `io_free` is all zero.
- R3: A request addresses the punch when its code is 10 (binary 01010) and its qualifier is 0. With code 10 and qualifier 1, `reader_req` is raised combinationally for that unit. Any other code addresses neither device, and that request gets no admit and no refuse.
- R4: A punch request is admitted when, at the sampling clock edge, there is no owner, `dev_avail` is high and `pn_ready` is high. If several units request at once, the lowest-indexed requester is admitted. The admitted unit gets a one-cycle `admit` pulse after that edge, and its `owned` bit is set from the same edge.
- R5: Every punch request that is not admitted gets a one-cycle `refuse` pulse after the sampling edge. This covers losers of a simultaneous request, requests made while any unit owns the punch (the owner included), and requests made while the punch is unavailable or not ready.
- R6: `owned` has at most one bit set. It holds until the owner's `io_done` bit is sampled high, and it is cleared at that edge. An `io_done` from a non-owner has no effect.
- R7: `pn_start`, `pn_pclk`, `pn_stack` and `pn_data` equal the owner's corresponding inputs. They are zero when there is no owner. Lines from non-owners have no effect.
- R8: `u_ready`, `u_cycle`, `u_err`, `u_need` and the unit's 4-bit slice of `u_row` (bits 4i+3..4i) carry the punch's lines to the owner only. They are zero for every other unit.
- R9: After reset, `owned`, `admit` and `refuse` are all zero.
- R10: After ownership is released, a new punch request from a previously refused unit is admitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | New I/O initiation |
| io_free | input | 4 | Per-unit free flags |
| init_sel | output | 4 | One-hot chosen I/O unit |
| init_none | output | 1 | No I/O unit free |
| req_valid | input | 4 | Per-unit descriptor request |
| req_code | input | 20 | Per-unit 5-bit unit-designate code |
| req_qual | input | 4 | Per-unit device qualifier bit |
| io_done | input | 4 | Per-unit completion, releases ownership |
| dev_avail | input | 1 | Punch present and switched to the system |
| admit | output | 4 | One-cycle admit pulse |
| refuse | output | 4 | One-cycle busy/refuse pulse |
| owned | output | 4 | Exchange enable flops, one per unit |
| reader_req | output | 4 | Request addressed to the reader |
| u_start | input | 4 | Per-unit start punch line |
| u_pclk | input | 4 | Per-unit punch clock pulse |
| u_stack | input | 4 | Per-unit auxiliary stacker select |
| u_data | input | 4 | Per-unit serial data bit |
| pn_start | output | 1 | Start to punch |
| pn_pclk | output | 1 | Clock pulse to punch |
| pn_stack | output | 1 | Stacker select to punch |
| pn_data | output | 1 | Serial data to punch |
| pn_ready | input | 1 | Punch ready |
| pn_cycle | input | 1 | Punch cycle in progress |
| pn_err | input | 1 | Punch error |
| pn_need | input | 1 | Punch needs information |
| pn_row | input | 4 | Row code being punched |
| u_ready | output | 4 | Ready, routed per unit |
| u_cycle | output | 4 | Cycle in progress, routed per unit |
| u_err | output | 4 | Error, routed per unit |
| u_need | output | 4 | Information needed, routed per unit |
| u_row | output | 16 | Row code, 4 bits per unit |

## Verification
The hardest situation to reach is contention: two units asking in the same cycle, and a unit asking while another already owns the punch. The bench drives two requests on one edge to test the lowest-index rule. While the punch is owned, it drives a request from a third unit and a completion from a non-owner to show that ownership does not move. It then releases ownership and retries the refused unit. Routing is checked with the owner's lines and a non-owner's lines set to opposite values, so a wrong gate shows at the punch pins.

// File: rtl/xs_pkg.sv
// Shared constants for the exchange selector.
// Assumes the outgoing bundle order {start, pclk, stack, data} and the
// return bundle order {ready, cycle, err, need, row}.
package xs_pkg;
    localparam int UNIT_W    = 5;
    localparam int PUNCH_ID  = 10;
    localparam int OUT_W     = 4;
    localparam int OUT_START = 3;
    localparam int OUT_PCLK  = 2;
    localparam int OUT_STACK = 1;
    localparam int OUT_DATA  = 0;
endpackage

// File: rtl/xs_decode.sv
// Unit-designate decoder: separates the punch from the reader that shares
// one code. Assumes the qualifier is meaningful only when valid is high.
module xs_decode #(
    parameter int CODE_W = 5,
    parameter int DEV_ID = 10
) (
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    input  logic              qual,
    output logic              punch_hit,
    output logic              reader_hit
);
    logic code_match;

    // Compare the code and split the two devices on the qualifier.
    always_comb begin
        code_match = valid && (code == CODE_W'(DEV_ID));
        punch_hit  = code_match && !qual;
        reader_hit = code_match && qual;
    end
endmodule

// File: rtl/xs_lowest.sv
// Lowest-index-first selector: one-hot on the least significant set bit.
// Assumes the caller qualifies req beforehand.
module xs_lowest #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // Walk upward and keep only the first request found.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/xs_route.sv
// Exchange matrix: ORs the enabled units' outgoing lines toward the
// peripheral and returns the peripheral's lines to the enabled unit only.
// Assumes at most one enable is set.
module xs_route #(
    parameter int N     = 4,
    parameter int OUT_W = 4,
    parameter int RET_W = 8
) (
    input  logic [N-1:0]       en,
    input  logic [N*OUT_W-1:0] u_out,
    output logic [OUT_W-1:0]   p_out,
    input  logic [RET_W-1:0]   p_ret,
    output logic [N*RET_W-1:0] u_ret
);
    // Common OR network over the gated per-unit outgoing bundles.
    always_comb begin
        p_out = '0;
        for (int i = 0; i < N; i++)
            p_out = p_out | (u_out[i*OUT_W +: OUT_W] & {OUT_W{en[i]}});
    end

    // Return path: only the enabled unit sees the peripheral.
    for (genvar g = 0; g < N; g++) begin : g_ret
        assign u_ret[g*RET_W +: RET_W] = en[g] ? p_ret : '0;
    end
endmodule

// File: rtl/xs_exchange.sv
// Exchange selector for one shared punch and four I/O units. It picks the
// lowest free unit for new work, admits one requester at a time, refuses
// the others with a busy pulse, and routes lines for the owner.
// Assumes the owner raises io_done for at least one clock to release.
module xs_exchange #(
    parameter int N     = 4,
    parameter int ROW_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         init_req,
    input  logic [N-1:0]                 io_free,
    output logic [N-1:0]                 init_sel,
    output logic                         init_none,
    input  logic [N-1:0]                 req_valid,
    input  logic [N*xs_pkg::UNIT_W-1:0]  req_code,
    input  logic [N-1:0]                 req_qual,
    input  logic [N-1:0]                 io_done,
    input  logic                         dev_avail,
    output logic [N-1:0]                 admit,
    output logic [N-1:0]                 refuse,
    output logic [N-1:0]                 owned,
    output logic [N-1:0]                 reader_req,
    input  logic [N-1:0]                 u_start,
    input  logic [N-1:0]                 u_pclk,
    input  logic [N-1:0]                 u_stack,
    input  logic [N-1:0]                 u_data,
    output logic                         pn_start,
    output logic                         pn_pclk,
    output logic                         pn_stack,
    output logic                         pn_data,
    input  logic                         pn_ready,
    input  logic                         pn_cycle,
    input  logic                         pn_err,
    input  logic                         pn_need,
    input  logic [ROW_W-1:0]             pn_row,
    output logic [N-1:0]                 u_ready,
    output logic [N-1:0]                 u_cycle,
    output logic [N-1:0]                 u_err,
    output logic [N-1:0]                 u_need,
    output logic [N*ROW_W-1:0]           u_row
);
    import xs_pkg::*;
    localparam int RET_W = ROW_W + 4;

    logic [N-1:0]       init_gnt;
    logic               init_any;
    logic [N-1:0]       punch_req;
    logic [N-1:0]       win;
    logic               win_any;
    logic               can_admit;
    logic [N-1:0]       grant;
    logic [N-1:0]       owner_q;
    logic [N-1:0]       admit_q;
    logic [N-1:0]       refuse_q;
    logic [N*OUT_W-1:0] out_bus;
    logic [OUT_W-1:0]   p_out;
    logic [RET_W-1:0]   p_ret;
    logic [N*RET_W-1:0] u_ret;

    // Initiation: lowest-numbered free unit.
    xs_lowest #(.N(N)) u_init (.req(io_free), .gnt(init_gnt), .any(init_any));

    // Qualify the initiation result with the request strobe.
    always_comb begin
        init_sel  = init_req ? init_gnt : '0;
        init_none = init_req && !init_any;
    end

    // Per-unit decode and bundle packing.
    for (genvar g = 0; g < N; g++) begin : g_unit
        xs_decode #(.CODE_W(UNIT_W), .DEV_ID(PUNCH_ID)) u_dec (
            .valid     (req_valid[g]),
            .code      (req_code[g*UNIT_W +: UNIT_W]),
            .qual      (req_qual[g]),
            .punch_hit (punch_req[g]),
            .reader_hit(reader_req[g])
        );
        assign out_bus[g*OUT_W + OUT_START] = u_start[g];
        assign out_bus[g*OUT_W + OUT_PCLK]  = u_pclk[g];
        assign out_bus[g*OUT_W + OUT_STACK] = u_stack[g];
        assign out_bus[g*OUT_W + OUT_DATA]  = u_data[g];
        assign u_ready[g] = u_ret[g*RET_W + ROW_W + 3];
        assign u_cycle[g] = u_ret[g*RET_W + ROW_W + 2];
        assign u_err[g]   = u_ret[g*RET_W + ROW_W + 1];
        assign u_need[g]  = u_ret[g*RET_W + ROW_W];
        assign u_row[g*ROW_W +: ROW_W] = u_ret[g*RET_W +: ROW_W];
    end

    // Admission arbitration among punch requesters.
    xs_lowest #(.N(N)) u_arb (.req(punch_req), .gnt(win), .any(win_any));

    // Admission is possible only with a free, present and ready punch.
    always_comb begin
        can_admit = (owner_q == '0) && dev_avail && pn_ready && win_any;
        grant     = can_admit ? win : '0;
    end

    // Ownership, admit and refuse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= '0;
            admit_q  <= '0;
            refuse_q <= '0;
        end else begin
            admit_q  <= grant;
            refuse_q <= punch_req & ~grant;
            if (owner_q == '0)
                owner_q <= grant;
            else if ((owner_q & io_done) != '0)
                owner_q <= '0;
        end
    end

    assign admit  = admit_q;
    assign refuse = refuse_q;
    assign owned  = owner_q;
    assign p_ret  = {pn_ready, pn_cycle, pn_err, pn_need, pn_row};

    // Exchange matrix.
    xs_route #(.N(N), .OUT_W(OUT_W), .RET_W(RET_W)) u_route (
        .en   (owner_q),
        .u_out(out_bus),
        .p_out(p_out),
        .p_ret(p_ret),
        .u_ret(u_ret)
    );

    assign pn_start = p_out[OUT_START];
    assign pn_pclk  = p_out[OUT_PCLK];
    assign pn_stack = p_out[OUT_STACK];
    assign pn_data  = p_out[OUT_DATA];
endmodule

// File: rtl/xs_exchange_chk.sv
// Property checker for the exchange selector; attached by bind below.
module xs_exchange_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] admit,
    input logic [N-1:0] refuse,
    input logic [N-1:0] owned,
    input logic [N-1:0] io_done,
    input logic         dev_avail,
    input logic         pn_ready,
    input logic         pn_start,
    input logic         pn_pclk,
    input logic         pn_stack,
    input logic         pn_data
);
    // R6: a single owner at most.
    assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owned));

    // R5: no unit is admitted and refused together.
    assert_admit_xor_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (admit & refuse) == '0);

    // R4: an admit follows a free, available and ready cycle.
    assert_admit_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (admit != '0) |-> ($past(owned) == '0 && $past(dev_avail) && $past(pn_ready)));

    // R4: an admitted unit owns the punch.
    assert_admit_owns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (admit != '0) |-> (owned == admit));

    // R6: ownership holds until its own done.
    assert_owner_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (owned != '0 && (owned & io_done) == '0) |=> (owned == $past(owned)));

    // R7: the punch sees nothing without an owner.
    assert_idle_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (owned == '0) |-> !(pn_start || pn_pclk || pn_stack || pn_data));
endmodule

bind xs_exchange xs_exchange_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .admit    (admit),
    .refuse   (refuse),
    .owned    (owned),
    .io_done  (io_done),
    .dev_avail(dev_avail),
    .pn_ready (pn_ready),
    .pn_start (pn_start),
    .pn_pclk  (pn_pclk),
    .pn_stack (pn_stack),
    .pn_data  (pn_data)
);

// File: tb/tb_xs_exchange.sv
// Directed bench for the exchange selector.
module tb_xs_exchange;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        init_req;
    logic [3:0]  io_free;
    logic [3:0]  init_sel;
    logic        init_none;
    logic [3:0]  req_valid;
    logic [19:0] req_code;
    logic [3:0]  req_qual;
    logic [3:0]  io_done;
    logic        dev_avail;
    logic [3:0]  admit, refuse, owned, reader_req;
    logic [3:0]  u_start, u_pclk, u_stack, u_data;
    logic        pn_start, pn_pclk, pn_stack, pn_data;
    logic        pn_ready, pn_cycle, pn_err, pn_need;
    logic [3:0]  pn_row;
    logic [3:0]  u_ready, u_cycle, u_err, u_need;
    logic [15:0] u_row;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    xs_exchange dut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .io_free(io_free),
        .init_sel(init_sel), .init_none(init_none), .req_valid(req_valid),
        .req_code(req_code), .req_qual(req_qual), .io_done(io_done),
        .dev_avail(dev_avail), .admit(admit), .refuse(refuse), .owned(owned),
        .reader_req(reader_req), .u_start(u_start), .u_pclk(u_pclk),
        .u_stack(u_stack), .u_data(u_data), .pn_start(pn_start),
        .pn_pclk(pn_pclk), .pn_stack(pn_stack), .pn_data(pn_data),
        .pn_ready(pn_ready), .pn_cycle(pn_cycle), .pn_err(pn_err),
        .pn_need(pn_need), .pn_row(pn_row), .u_ready(u_ready),
        .u_cycle(u_cycle), .u_err(u_err), .u_need(u_need), .u_row(u_row)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request per selected unit for one clock, then clear it.
    task automatic request(input logic [3:0] units, input logic [4:0] code, input logic qual);
        @(negedge clk);
        req_valid = units;
        for (int i = 0; i < 4; i++) begin
            req_code[i*5 +: 5] = code;
            req_qual[i] = qual;
        end
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic pulse_done(input logic [3:0] units);
        @(negedge clk);
        io_done = units;
        @(negedge clk);
        io_done = '0;
    endtask

    task automatic t_reset;
        check("R9 owned", 32'(owned), 0);
        check("R9 admit", 32'(admit), 0);
        check("R9 refuse", 32'(refuse), 0);
    endtask

    task automatic t_init;
        @(negedge clk);
        init_req = 1'b1; io_free = 4'b1100; #1;
        check("R1 lowest free", 32'(init_sel), 32'b0100);
        io_free = 4'b1111; #1;
        check("R1 unit1 free", 32'(init_sel), 32'b0001);
        io_free = 4'b0000; #1;
        check("R2 none free", 32'(init_none), 1);
        check("R1 none sel", 32'(init_sel), 0);
        init_req = 1'b0; io_free = 4'b1111; #1;
        check("R1 idle sel", 32'(init_sel), 0);
        check("R2 idle none", 32'(init_none), 0);
    endtask

    task automatic t_decode;
        @(negedge clk);
        req_valid = 4'b0001; req_code = {4{5'd10}}; req_qual = 4'b1111; #1;
        check("R3 reader decode", 32'(reader_req), 32'b0001);
        @(negedge clk);
        req_valid = '0;
        check("R3 reader no admit", 32'(admit), 0);
        check("R3 reader no refuse", 32'(refuse), 0);
        request(4'b0001, 5'd11, 1'b0);
        check("R3 other code no admit", 32'(admit), 0);
        check("R3 other code no refuse", 32'(refuse), 0);
        check("R3 other code reader", 32'(reader_req), 0);
    endtask

    task automatic t_grant;
        request(4'b1010, 5'd10, 1'b0);
        check("R4 lowest admitted", 32'(admit), 32'b0010);
        check("R5 loser refused", 32'(refuse), 32'b1000);
        check("R4 owner set", 32'(owned), 32'b0010);
        @(negedge clk);
        check("R4 admit one cycle", 32'(admit), 0);
    endtask

    task automatic t_route;
        u_start = 4'b1111; u_pclk = 4'b1101; u_stack = 4'b0010; u_data = 4'b1101; #1;
        check("R7 start", 32'(pn_start), 1);
        check("R7 pclk from owner", 32'(pn_pclk), 0);
        check("R7 stack from owner", 32'(pn_stack), 1);
        check("R7 data ignores others", 32'(pn_data), 0);
        u_data = 4'b0010; #1;
        check("R7 data follows owner", 32'(pn_data), 1);
        pn_row = 4'hA; pn_need = 1'b1; pn_err = 1'b1; pn_cycle = 1'b1; #1;
        check("R8 row to owner", 32'(u_row), 32'h00A0);
        check("R8 need to owner", 32'(u_need), 32'b0010);
        check("R8 err to owner", 32'(u_err), 32'b0010);
        check("R8 ready to owner", 32'(u_ready), 32'b0010);
        check("R8 cycle to owner", 32'(u_cycle), 32'b0010);
    endtask

    task automatic t_busy;
        request(4'b0001, 5'd10, 1'b0);
        check("R5 busy refused", 32'(refuse), 32'b0001);
        check("R5 busy no admit", 32'(admit), 0);
        check("R6 owner kept", 32'(owned), 32'b0010);
        request(4'b0010, 5'd10, 1'b0);
        check("R5 owner re-request refused", 32'(refuse), 32'b0010);
        pulse_done(4'b0001);
        check("R6 foreign done ignored", 32'(owned), 32'b0010);
    endtask

    task automatic t_release_retry;
        pulse_done(4'b0010);
        check("R6 released", 32'(owned), 0);
        #1;
        check("R7 idle start", 32'(pn_start), 0);
        check("R8 idle row", 32'(u_row), 0);
        request(4'b0001, 5'd10, 1'b0);
        check("R10 retry admitted", 32'(admit), 32'b0001);
        check("R10 retry owns", 32'(owned), 32'b0001);
        pulse_done(4'b0001);
        check("R6 released again", 32'(owned), 0);
    endtask

    task automatic t_not_ready;
        @(negedge clk);
        pn_ready = 1'b0;
        request(4'b0100, 5'd10, 1'b0);
        check("R5 not ready refused", 32'(refuse), 32'b0100);
        check("R5 not ready no owner", 32'(owned), 0);
        pn_ready = 1'b1; dev_avail = 1'b0;
        request(4'b0100, 5'd10, 1'b0);
        check("R5 unavailable refused", 32'(refuse), 32'b0100);
        check("R5 unavailable no admit", 32'(admit), 0);
        dev_avail = 1'b1;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; init_req = 1'b0; io_free = '0; req_valid = '0;
        req_code = '0; req_qual = '0; io_done = '0; dev_avail = 1'b1;
        u_start = '0; u_pclk = '0; u_stack = '0; u_data = '0;
        pn_ready = 1'b1; pn_cycle = 1'b0; pn_err = 1'b0; pn_need = 1'b0; pn_row = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_decode();
        t_grant();
        t_route();
        t_busy();
        t_release_retry();
        t_not_ready();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule